// File: doc/BRIEF.md
# Text Page Streamer for Character Displays

This block prints a zero-terminated text string, held in a 256-entry page of program ROM, on a character display controller. A single start pulse supplies the ROM page number, a byte index that points one entry *before* the first character, a zero-based screen position (0 is the top line, left end), and a flag that asks for a screen clear first.

The block reads characters through a synchronous ROM port with one cycle of read latency. It sends command bytes and character bytes to the display through a valid/ready interface. A flag beside the byte marks it as a command or as data. The display advances its own address after each character, so ordinary characters go out without a new address.

The display does not advance across the boundary from the first line to the second line. For that reason the code 0xFE is never displayed. It makes the block move the display address to 0x10, the start of the second line. After the screen-clear command the block waits a fixed time, 5 ms by default, counted in clock cycles from a clock-frequency parameter. Then it continues.

Top module: `lcd_str_streamer`

## Requirements
- R1: While reset is high, and in the cycle after it, `lcd_valid`, `busy`, `done` and `rom_rd` are all low.
- R2: The first write of a string without a clear is the command `0x80 | cursor`. With a clear it is the second write. `cursor` is the position captured with the start pulse, and later changes on the start inputs have no effect on the run.
- R3: The first ROM read of a run is at `{page, index+1}`. Each later read is one entry higher. The low byte wraps from 0xFF to 0x00 inside the same page.
- R4: A fetched byte 0x00 ends the run. It is not written, no further display write follows, `done` is high for exactly one cycle, and `busy` is low when `done` is high.
- R5: A fetched byte 0xFE is not written as data. Instead the command 0x90 (set address to 0x10) is written.
- R6: Every other nonzero byte is written as data (`lcd_is_cmd` low), in ROM order, with no address command before it.
- R7: With the clear flag set, the first write is the command 0x01. At least CLEAR_US microseconds of clock cycles (CLK_HZ/1000*CLEAR_US/1000) pass between its acceptance and the next display write.
- R8: While `lcd_valid` is high and `lcd_ready` is low, `lcd_valid`, `lcd_is_cmd` and `lcd_byte` hold their values.
- R9: A start pulse received while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_page | input | PAGE_W | ROM page that holds the string |
| start_idx | input | IDX_W | Index of the first character minus one |
| start_cursor | input | 7 | Zero-based display position of the first character |
| start_clear | input | 1 | Clear the screen and wait before printing |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the terminator is read |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | PAGE_W+IDX_W | ROM read address {page, index} |
| rom_data | input | 8 | ROM read data, valid one cycle after `rom_rd` |
| lcd_valid | output | 1 | Display write pending |
| lcd_ready | input | 1 | Display accepts the pending write |
| lcd_is_cmd | output | 1 | 1 for a command write, 0 for character data |
| lcd_byte | output | 8 | Command or character byte |

## Verification
The bound checker watches several rules on every cycle:
- the reset state;
- the opening address command;
- the step and page wrap of each ROM address;
- the single-cycle `done` pulse;
- that neither 0x00 nor 0xFE ever appears as data;
- that a stalled write holds its value;
- the minimum gap after a clear.

Some properties only the bench scenarios can show, because they compare complete output streams with a reference computed from the ROM image:
- the exact order of characters and line-break commands;
- that nothing follows the terminator;
- that a start pulse or new start values received in mid-run do not change the run.

These scenarios include strings that wrap inside the page, strings that are empty, and strings with two 0xFE codes in a row.

// File: rtl/lcd_str_pkg.sv
package lcd_str_pkg;

  localparam int          ADR_W      = 7;       // display address width
  localparam logic [7:0]  CMD_CLEAR  = 8'h01;
  localparam logic [7:0]  CMD_SETADR = 8'h80;
  localparam logic [7:0]  CH_END     = 8'h00;
  localparam logic [7:0]  CH_NEWLINE = 8'hFE;
  localparam logic [ADR_W-1:0] LINE2_ADR = 7'h10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_WAIT,
    ST_SEND,
    ST_READ,
    ST_CHECK
  } st_e;

  function automatic logic [7:0] set_adr(input logic [ADR_W-1:0] a);
    return CMD_SETADR | {1'b0, a};
  endfunction

endpackage

// File: rtl/lcd_str_delay.sv
module lcd_str_delay #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (arm) begin
      cnt     <= CW'(CYCLES);
      running <= 1'b1;
    end else if (running) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else           running <= 1'b0;
    end
  end

  assign expired = running && (cnt == '0);
endmodule

// File: rtl/lcd_str_fetch.sv
module lcd_str_fetch #(
  parameter int PAGE_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [PAGE_W-1:0]       page_in,
  input  logic [IDX_W-1:0]        idx_in,
  input  logic                    step,
  output logic                    rom_rd,
  output logic [PAGE_W+IDX_W-1:0] rom_addr
);
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      idx_q  <= '0;
      rom_rd <= 1'b0;
    end else begin
      rom_rd <= step;
      if (load) begin
        page_q <= page_in;
        idx_q  <= idx_in;
      end else if (step) begin
        idx_q  <= idx_q + 1'b1;     // pre-increment, wraps inside page
      end
    end
  end

  assign rom_addr = {page_q, idx_q};
endmodule

// File: rtl/lcd_str_out.sv
module lcd_str_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       push_cmd,
  input  logic [7:0] push_byte,
  input  logic       ready,
  output logic       valid,
  output logic       is_cmd,
  output logic [7:0] data,
  output logic       accepted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      is_cmd <= 1'b0;
      data   <= '0;
    end else if (push) begin
      valid  <= 1'b1;
      is_cmd <= push_cmd;
      data   <= push_byte;
    end else if (valid && ready) begin
      valid  <= 1'b0;
    end
  end

  assign accepted = valid && ready;
endmodule

// File: rtl/lcd_str_streamer.sv
module lcd_str_streamer
  import lcd_str_pkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int IDX_W    = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int CLEAR_US = 5000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [PAGE_W-1:0]       start_page,
  input  logic [IDX_W-1:0]        start_idx,
  input  logic [ADR_W-1:0]        start_cursor,
  input  logic                    start_clear,
  output logic                    busy,
  output logic                    done,
  output logic                    rom_rd,
  output logic [PAGE_W+IDX_W-1:0] rom_addr,
  input  logic [7:0]              rom_data,
  output logic                    lcd_valid,
  input  logic                    lcd_ready,
  output logic                    lcd_is_cmd,
  output logic [7:0]              lcd_byte
);
  localparam int DLY_RAW = CLK_HZ / 1000 * CLEAR_US / 1000;
  localparam int DLY_CYC = (DLY_RAW < 1) ? 1 : DLY_RAW;

  st_e              st, st_n;
  logic [ADR_W-1:0] cur_q;
  logic             push, push_cmd;
  logic [7:0]       push_byte;
  logic             f_load, f_step, arm, expired, acc;

  lcd_str_delay #(.CYCLES(DLY_CYC)) i_delay (
    .clk(clk), .rst(rst), .arm(arm), .expired(expired)
  );

  lcd_str_fetch #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) i_fetch (
    .clk(clk), .rst(rst), .load(f_load), .page_in(start_page),
    .idx_in(start_idx), .step(f_step), .rom_rd(rom_rd), .rom_addr(rom_addr)
  );

  lcd_str_out i_out (
    .clk(clk), .rst(rst), .push(push), .push_cmd(push_cmd),
    .push_byte(push_byte), .ready(lcd_ready), .valid(lcd_valid),
    .is_cmd(lcd_is_cmd), .data(lcd_byte), .accepted(acc)
  );

  always_comb begin
    st_n      = st;
    push      = 1'b0;
    push_cmd  = 1'b0;
    push_byte = '0;
    f_load    = 1'b0;
    f_step    = 1'b0;
    arm       = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        f_load   = 1'b1;
        push     = 1'b1;
        push_cmd = 1'b1;
        if (start_clear) begin
          push_byte = CMD_CLEAR;
          st_n      = ST_CLR;
        end else begin
          push_byte = set_adr(start_cursor);
          st_n      = ST_SEND;
        end
      end
      ST_CLR: if (acc) begin
        arm  = 1'b1;
        st_n = ST_WAIT;
      end
      ST_WAIT: if (expired) begin
        push      = 1'b1;
        push_cmd  = 1'b1;
        push_byte = set_adr(cur_q);
        st_n      = ST_SEND;
      end
      ST_SEND: if (acc) begin
        f_step = 1'b1;
        st_n   = ST_READ;
      end
      ST_READ: st_n = ST_CHECK;
      ST_CHECK: begin
        if (rom_data == CH_END) begin
          st_n = ST_IDLE;
        end else if (rom_data == CH_NEWLINE) begin
          push      = 1'b1;
          push_cmd  = 1'b1;
          push_byte = set_adr(LINE2_ADR);
          st_n      = ST_SEND;
        end else begin
          push      = 1'b1;
          push_byte = rom_data;
          st_n      = ST_SEND;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cur_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      st   <= st_n;
      busy <= (st_n != ST_IDLE);
      done <= (st == ST_CHECK) && (rom_data == CH_END);
      if (st == ST_IDLE && start) cur_q <= start_cursor;
    end
  end
endmodule

// File: rtl/lcd_str_check.sv
module lcd_str_check #(
  parameter int PAGE_W   = 8,
  parameter int IDX_W    = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int CLEAR_US = 5000
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic [PAGE_W-1:0]       start_page,
  input logic [IDX_W-1:0]        start_idx,
  input logic [6:0]              start_cursor,
  input logic                    start_clear,
  input logic                    busy,
  input logic                    done,
  input logic                    rom_rd,
  input logic [PAGE_W+IDX_W-1:0] rom_addr,
  input logic                    lcd_valid,
  input logic                    lcd_ready,
  input logic                    lcd_is_cmd,
  input logic [7:0]              lcd_byte
);
  localparam int DLY_RAW = CLK_HZ / 1000 * CLEAR_US / 1000;
  localparam int DLY_CYC = (DLY_RAW < 1) ? 1 : DLY_RAW;

  logic                    taken, have_prev, waiting;
  logic [PAGE_W-1:0]       sp;
  logic [IDX_W-1:0]        si;
  logic [PAGE_W+IDX_W-1:0] prev;
  int unsigned             gap;

  assign taken = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      sp        <= '0;
      si        <= '0;
      prev      <= '0;
      waiting   <= 1'b0;
      gap       <= 0;
    end else begin
      if (taken) begin
        have_prev <= 1'b0;
        sp        <= start_page;
        si        <= start_idx;
      end else if (rom_rd) begin
        have_prev <= 1'b1;
        prev      <= rom_addr;
      end
      if (lcd_valid && lcd_ready && lcd_is_cmd && lcd_byte == 8'h01) begin
        waiting <= 1'b1;
        gap     <= 0;
      end else if (waiting) begin
        gap <= gap + 1;
        if (lcd_valid) waiting <= 1'b0;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!lcd_valid && !busy && !done && !rom_rd));

  a_r2_open_cmd: assert property (@(posedge clk) disable iff (rst)
    (taken && !start_clear) |=> (lcd_valid && lcd_is_cmd &&
      lcd_byte == {1'b1, $past(start_cursor)}));

  a_r3_first_fetch: assert property (@(posedge clk) disable iff (rst)
    (rom_rd && !have_prev) |-> (rom_addr == {sp, si + 1'b1}));

  a_r3_step_fetch: assert property (@(posedge clk) disable iff (rst)
    (rom_rd && have_prev) |->
      (rom_addr[PAGE_W+IDX_W-1:IDX_W] == prev[PAGE_W+IDX_W-1:IDX_W] &&
       rom_addr[IDX_W-1:0] == prev[IDX_W-1:0] + 1'b1));

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_no_special_data: assert property (@(posedge clk) disable iff (rst)
    (lcd_valid && !lcd_is_cmd) |-> (lcd_byte != 8'h00 && lcd_byte != 8'hFE));

  a_r7_clear_gap: assert property (@(posedge clk) disable iff (rst)
    (waiting && lcd_valid) |-> (gap >= DLY_CYC));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (lcd_valid && !lcd_ready) |=>
      (lcd_valid && $stable(lcd_byte) && $stable(lcd_is_cmd)));
endmodule

bind lcd_str_streamer lcd_str_check #(
  .PAGE_W(PAGE_W), .IDX_W(IDX_W), .CLK_HZ(CLK_HZ), .CLEAR_US(CLEAR_US)
) i_lcd_str_check (
  .clk(clk), .rst(rst), .start(start), .start_page(start_page),
  .start_idx(start_idx), .start_cursor(start_cursor),
  .start_clear(start_clear), .busy(busy), .done(done), .rom_rd(rom_rd),
  .rom_addr(rom_addr), .lcd_valid(lcd_valid), .lcd_ready(lcd_ready),
  .lcd_is_cmd(lcd_is_cmd), .lcd_byte(lcd_byte)
);

// File: tb/test_lcd_str_streamer.sv
module test_lcd_str_streamer;
  localparam int PAGE_W = 8, IDX_W = 8, CLK_HZ = 50_000_000, CLEAR_US = 1;
  localparam int DLY = CLK_HZ / 1000 * CLEAR_US / 1000;   // 50 cycles

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst, start, start_clear, busy, done, rom_rd;
  logic [7:0]  start_page, start_idx, rom_data, lcd_byte;
  logic [6:0]  start_cursor;
  logic [15:0] rom_addr;
  logic        lcd_valid, lcd_ready, lcd_is_cmd;

  lcd_str_streamer #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .CLK_HZ(CLK_HZ),
                     .CLEAR_US(CLEAR_US)) i_lcd_str_streamer (
    .clk(clk), .rst(rst), .start(start), .start_page(start_page),
    .start_idx(start_idx), .start_cursor(start_cursor),
    .start_clear(start_clear), .busy(busy), .done(done), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .rom_data(rom_data), .lcd_valid(lcd_valid),
    .lcd_ready(lcd_ready), .lcd_is_cmd(lcd_is_cmd), .lcd_byte(lcd_byte)
  );

  // ROM model: four pages, one cycle read latency
  logic [7:0] rom [0:1023];
  logic [7:0] rom_q = 8'h00;
  always @(posedge clk) if (rom_rd) rom_q <= rom[rom_addr[9:0]];
  assign rom_data = rom_q;

  initial lcd_ready = 1'b0;
  always @(negedge clk) lcd_ready <= ($urandom % 4) != 0;

  int tests = 0, fails = 0;
  bit finished = 0;

  // logging
  bit         log_en = 0;
  logic [8:0] log_w [0:599];
  int         log_t [0:599];
  logic [15:0] log_a [0:299];
  int log_n, log_an, done_n, hold_bad, cyc = 0;
  bit hold_pend = 0;
  logic [8:0] hold_v;

  always @(posedge clk) begin
    cyc++;
    if (log_en) begin
      if (hold_pend && !(lcd_valid && {lcd_is_cmd, lcd_byte} == hold_v)) hold_bad++;
      hold_pend = lcd_valid && !lcd_ready;
      hold_v    = {lcd_is_cmd, lcd_byte};
      if (lcd_valid && lcd_ready && log_n < 600) begin
        log_w[log_n] = {lcd_is_cmd, lcd_byte};
        log_t[log_n] = cyc;
        log_n++;
      end
      if (rom_rd && log_an < 300) begin
        log_a[log_an] = rom_addr;
        log_an++;
      end
      if (done) done_n++;
    end
  end

  // expected stream
  logic [8:0]  exp_w [0:599];
  logic [15:0] exp_a [0:299];
  int exp_n, exp_an;

  task automatic build_exp(input logic [7:0] pg, input logic [7:0] ix,
                           input logic [6:0] cu, input bit cl);
    logic [7:0] i, b;
    exp_n = 0; exp_an = 0;
    if (cl) begin exp_w[exp_n] = {1'b1, 8'h01}; exp_n++; end
    exp_w[exp_n] = {1'b1, 1'b1, cu}; exp_n++;
    i = ix;
    forever begin
      i = i + 8'd1;
      exp_a[exp_an] = {pg, i}; exp_an++;
      b = rom[{pg[1:0], i}];
      if (b == 8'h00) break;
      if (b == 8'hFE) exp_w[exp_n] = {1'b1, 8'h90};
      else            exp_w[exp_n] = {1'b0, b};
      exp_n++;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic run_case(input logic [7:0] pg, input logic [7:0] ix,
                          input logic [6:0] cu, input bit cl);
    int t;
    build_exp(pg, ix, cu, cl);
    log_n = 0; log_an = 0; done_n = 0; hold_bad = 0; hold_pend = 0;
    log_en = 1;
    @(negedge clk);
    start = 1; start_page = pg; start_idx = ix; start_cursor = cu; start_clear = cl;
    @(negedge clk);
    start = 0;
    start_page = 8'($urandom % 4); start_idx = 8'($urandom);
    start_cursor = 7'($urandom); start_clear = 1'($urandom);
    repeat (2) @(negedge clk);
    if (busy) begin            // R9: a start while busy must be ignored
      start = 1; @(negedge clk); start = 0;
    end
    t = 0;
    while (done_n == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    log_en = 0;
    chk(done_n == 1, "R4", "done pulse count", done_n, 1);
    chk(busy == 0, "R4", "busy after done", busy, 0);
    chk(log_n == exp_n, "R4", "write count (nothing after terminator)", log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++) begin
      if (exp_w[k] == {1'b1, 8'h90} && !(cl && k == 0) && k > (cl ? 1 : 0))
        chk(log_w[k] == exp_w[k], "R5", "newline command", log_w[k], exp_w[k]);
      else if (!exp_w[k][8])
        chk(log_w[k] == exp_w[k], "R6", "character data", log_w[k], exp_w[k]);
      else if (cl && k == 0)
        chk(log_w[k] == exp_w[k], "R7", "clear command", log_w[k], exp_w[k]);
      else
        chk(log_w[k] == exp_w[k], "R2", "opening address", log_w[k], exp_w[k]);
    end
    chk(log_an == exp_an, "R3", "fetch count", log_an, exp_an);
    for (int k = 0; k < exp_an && k < log_an; k++)
      chk(log_a[k] == exp_a[k], "R3", "fetch address", log_a[k], exp_a[k]);
    chk(hold_bad == 0, "R8", "stall hold violations", hold_bad, 0);
    if (cl && log_n > 1)
      chk((log_t[1] - log_t[0]) >= DLY + 1, "R7", "clear wait cycles",
          log_t[1] - log_t[0], DLY + 1);
  endtask

  initial begin
    #(20ns * 190000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 1024; a++) begin
      int r;
      r = $urandom % 20;
      rom[a] = (r == 0) ? 8'h00 : (r == 1) ? 8'hFE : 8'(8'h20 + $urandom % 90);
    end
    for (int p = 0; p < 4; p++) rom[p * 256 + 8'h55] = 8'h00;
    // wrap across the page end
    rom[256 + 8'hFE] = 8'h41; rom[256 + 8'hFF] = 8'h42;
    rom[256 + 8'h00] = 8'hFE; rom[256 + 8'h01] = 8'h43; rom[256 + 8'h02] = 8'h00;
    // two newlines in a row
    rom[768 + 8'h00] = 8'h5A; rom[768 + 8'h01] = 8'hFE;
    rom[768 + 8'h02] = 8'hFE; rom[768 + 8'h03] = 8'h00;

    rst = 1; start = 0; start_page = 0; start_idx = 0; start_cursor = 0; start_clear = 0;
    repeat (3) @(negedge clk);
    chk(!lcd_valid && !busy && !done && !rom_rd, "R1", "reset outputs",
        {lcd_valid, busy, done, rom_rd}, 0);
    rst = 0;
    @(negedge clk);
    chk(!lcd_valid && !busy, "R1", "idle after reset", {lcd_valid, busy}, 0);

    run_case(8'd1, 8'hFD, 7'd0,  1'b0);   // page wrap, R3
    run_case(8'd2, 8'h54, 7'd5,  1'b0);   // empty string, R4
    run_case(8'd3, 8'hFF, 7'h12, 1'b0);   // index FF -> first fetch 00, double newline R5
    run_case(8'd1, 8'hFD, 7'h40, 1'b1);   // with clear, R7
    run_case(8'd2, 8'h54, 7'd3,  1'b1);   // clear, then empty string
    for (int n = 0; n < 20; n++)
      run_case(8'($urandom % 4), 8'($urandom), 7'($urandom), ($urandom % 3) == 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule